// File: doc/BRIEF.md
# SD Host Register Access Adapter

This adapter lets a host-side bus that speaks standard SD host controller offsets, with byte, halfword and word accesses, drive a backing register file. That register file only stores aligned 32-bit words, and some of its fields sit at other bit positions than the standard expects. Every access addresses the aligned word. A sub-word read picks the addressed lane. A sub-word write reads the current word, replaces only its lane and writes the merged word back within the same accepted cycle. The backing file answers reads combinationally.

A small set of registers gets special treatment:
- Present-state and host-control fields are translated between the two layouts.
- The capabilities word may report an extra DMA capability.
- Interrupt-enable writes always keep the block-gap enable set.
- Block-size writes drop the boundary bits.
- Power-control byte writes are discarded.
- A transfer-mode halfword write is held in a shadow and is committed only together with the next command halfword write.

A static vendor version input and a version-quirk input complete the picture.

Top module: `sdhc_reg_adapter`

## Requirements
- R1: A word access (size code 2, or 3) reads or writes the backing word at the address with its two low bits cleared, unchanged unless a rule below applies.
- R2: A byte access (size code 0) uses lane (address mod 4): a read returns that byte zero-extended, and a write replaces only that byte of the backing word.
- R3: A halfword access (size code 1) uses lane bit 1 of the address (bits 15:0 or 31:16): a read returns that half zero-extended, and a write replaces only that half.
- R4: A word read at offset 0x24 returns backing bits 19:0 unchanged, backing bits 27:24 in bits 23:20, backing bit 23 in bit 24, and zero in bits 31:25.
- R5: A word read at offset 0x40 also reports bit 19 set when backing bit 20 is set and the vendor version input exceeds 0x12; otherwise the word is unchanged.
- R6: A halfword write at offset 0x0C changes no backing word and is kept in a shadow. A halfword write at 0x0E writes word 0x0C as {written value, shadow}. Reset clears the shadow to zero.
- R7: A byte write at offset 0x29 leaves the backing word unchanged.
- R8: A byte write at offset 0x28 with value v sets backing bits 9:8 to v[4:3]. Backing bits 4:3 are kept, and the other low-byte bits take v. The reserved bits of the low byte (bit 2 by default) are then cleared. The other bits are kept.
- R9: A byte read at offset 0x28 returns the low backing byte with bits 4:3 replaced by backing bits 9:8.
- R10: A halfword write at offset 0x04 clears backing bits 14:12 after the merge.
- R11: A word write at offset 0x34 always stores bit 2 as 1.
- R12: While the version-quirk input is high, a halfword read at 0xFE returns 0x1301; otherwise it returns the stored half.
- R13: An accepted request produces exactly one ready pulse, in the cycle after acceptance, and at most one backing write. Ready and read data are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Access request, held until hostReady |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| hostAddr | input | ADDR_W | Standard register byte offset |
| hostWdata | input | 32 | Write data, right-aligned |
| hostReady | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read data, right-aligned, valid with hostReady |
| vendorVer | input | 8 | Static vendor version of the backing file |
| wrongVerQuirk | input | 1 | Forces the fixed version answer |
| regAddr | output | ADDR_W | Word-aligned backing address |
| regWe | output | 1 | Backing write strobe |
| regWdata | output | 32 | Backing write word |
| regRdata | input | 32 | Backing word at regAddr, combinational |

## Verification
Two things can land in one accepted cycle. The first is the read of the old backing word that a sub-word write merges with. The second is the layout translation of that same word, or the shadow commit. The bench provokes this with host-control byte writes over a word whose power byte and native DMA bits are already set, and with a command halfword write right after a held transfer-mode write. It judges the outcome by reading the whole word back at word size and comparing it with a value derived by hand from the requirements. A reset between a held transfer-mode write and the command write shows that the shadow clears to zero.

// File: rtl/sdhc_adapt_pkg.sv
package sdhc_adapt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // request taken this cycle
    logic holdMode;   // transfer-mode half write goes to shadow
    logic dropWrite;  // no backing write for this access
  } ctrlStrobe_t;

  // standard register offsets the rules key on
  localparam int unsigned OFF_BLKSZ   = 'h04;
  localparam int unsigned OFF_XFER    = 'h0C;
  localparam int unsigned OFF_CMD     = 'h0E;
  localparam int unsigned OFF_PSTATE  = 'h24;
  localparam int unsigned OFF_HOSTCTL = 'h28;
  localparam int unsigned OFF_PWR     = 'h29;
  localparam int unsigned OFF_INTEN   = 'h34;
  localparam int unsigned OFF_CAPS    = 'h40;
  localparam int unsigned OFF_HOSTVER = 'hFE;

endpackage

// File: rtl/sdhc_adapt_ctrl.sv
module sdhc_adapt_ctrl
  import sdhc_adapt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  accSize_e          accSize,
  input  logic [ADDR_W-1:0] hostAddr,
  output ctrlStrobe_t       strobe,
  output logic              hostReady
);

  typedef enum logic {ST_IDLE, ST_DONE} state_e;
  state_e state;

  logic isXferHalf, isPwrByte;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else if (state == ST_IDLE && hostReq) state <= ST_DONE;
    else state <= ST_IDLE;
  end

  assign hostReady  = (state == ST_DONE);
  assign isXferHalf = (accSize == SZ_HALF) && (hostAddr == ADDR_W'(OFF_XFER));
  assign isPwrByte  = (accSize == SZ_BYTE) && (hostAddr == ADDR_W'(OFF_PWR));

  always_comb begin
    strobe.accept    = (state == ST_IDLE) && hostReq;
    strobe.holdMode  = strobe.accept && hostWe && isXferHalf;
    strobe.dropWrite = strobe.holdMode || (strobe.accept && hostWe && isPwrByte);
  end

  // R13: ready is a single pulse
  a_r13_single_ready: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady);

  // R13: a pending request is answered on the next cycle
  a_r13_ready_follows: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostReady) |=> hostReady);

endmodule

// File: rtl/sdhc_adapt_dp.sv
module sdhc_adapt_dp
  import sdhc_adapt_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [7:0]  RSVD_MASK    = 8'h04,
  parameter logic [7:0]  ADMA_MIN_VER = 8'h12,
  parameter logic [15:0] FIXED_VER    = 16'h1301
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              hostWe,
  input  accSize_e          accSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  input  logic [7:0]        vendorVer,
  input  logic              wrongVerQuirk,
  input  logic [31:0]       regRdata,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [31:0]       regWdata,
  output logic [31:0]       hostRdata
);

  localparam logic [31:0] BYTE_MASK = 32'h0000_00FF;
  localparam logic [31:0] HALF_MASK = 32'h0000_FFFF;

  logic [4:0]  laneShift;
  logic [15:0] xferShadow;
  logic [31:0] oldWord, newWord, rdWord;
  logic        atHostCtl, atBlkSz, atCmd, atInten, atPstate, atCaps, atHostVer;

  assign oldWord   = regRdata;
  assign regAddr   = {hostAddr[ADDR_W-1:2], 2'b00};
  assign atHostCtl = hostAddr == ADDR_W'(OFF_HOSTCTL);
  assign atBlkSz   = hostAddr == ADDR_W'(OFF_BLKSZ);
  assign atCmd     = hostAddr == ADDR_W'(OFF_CMD);
  assign atInten   = hostAddr == ADDR_W'(OFF_INTEN);
  assign atPstate  = hostAddr == ADDR_W'(OFF_PSTATE);
  assign atCaps    = hostAddr == ADDR_W'(OFF_CAPS);
  assign atHostVer = hostAddr == ADDR_W'(OFF_HOSTVER);

  always_comb begin
    case (accSize)
      SZ_BYTE: laneShift = {hostAddr[1:0], 3'b000};
      SZ_HALF: laneShift = {hostAddr[1], 4'b0000};
      default: laneShift = 5'd0;
    endcase
  end

  // write merge and layout fixups
  always_comb begin
    newWord = hostWdata;
    case (accSize)
      SZ_BYTE: begin
        newWord = (oldWord & ~(BYTE_MASK << laneShift))
                | ((hostWdata & BYTE_MASK) << laneShift);
        if (atHostCtl) begin
          newWord      = oldWord;
          newWord[9:8] = hostWdata[4:3];
          newWord[7:0] = {hostWdata[7:5], oldWord[4:3], hostWdata[2:0]} & ~RSVD_MASK;
        end
      end
      SZ_HALF: begin
        if (atCmd) newWord = {hostWdata[15:0], xferShadow};
        else newWord = (oldWord & ~(HALF_MASK << laneShift))
                     | ((hostWdata & HALF_MASK) << laneShift);
        if (atBlkSz) newWord[14:12] = 3'b000;
      end
      default: if (atInten) newWord[2] = 1'b1;
    endcase
  end

  // read lane select and layout fixups
  always_comb begin
    rdWord = oldWord;
    case (accSize)
      SZ_BYTE: begin
        rdWord = (oldWord >> laneShift) & BYTE_MASK;
        if (atHostCtl) rdWord[4:3] = oldWord[9:8];
      end
      SZ_HALF: begin
        rdWord = (oldWord >> laneShift) & HALF_MASK;
        if (atHostVer && wrongVerQuirk) rdWord = {16'h0000, FIXED_VER};
      end
      default: begin
        if (atPstate) rdWord = {7'b0, oldWord[23], oldWord[27:24], oldWord[19:0]};
        if (atCaps && oldWord[20] && (vendorVer > ADMA_MIN_VER)) rdWord[19] = 1'b1;
      end
    endcase
  end

  assign regWe    = strobe.accept && hostWe && !strobe.dropWrite;
  assign regWdata = newWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata  <= '0;
      xferShadow <= '0;
    end else begin
      if (strobe.accept && !hostWe) hostRdata <= rdWord;
      if (strobe.holdMode) xferShadow <= hostWdata[15:0];
    end
  end

  // R6: a transfer-mode half write never reaches the backing file
  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && hostWe && accSize == SZ_HALF && hostAddr == ADDR_W'(OFF_XFER)) |-> !regWe);

  // R7: power-control byte writes are dropped
  a_r7_power_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && hostWe && accSize == SZ_BYTE && hostAddr == ADDR_W'(OFF_PWR)) |-> !regWe);

  // R10: boundary bits never stored by a block-size half write
  a_r10_boundary_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && accSize == SZ_HALF && hostAddr == ADDR_W'(OFF_BLKSZ)) |-> (regWdata[14:12] == 3'b000));

  // R11: interrupt-enable word always carries the block-gap enable
  a_r11_blkgap_set: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && accSize inside {SZ_WORD, SZ_WIDE} && hostAddr == ADDR_W'(OFF_INTEN)) |-> regWdata[2]);

  // R8: reserved host-control bits are never stored
  a_r8_rsvd_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && accSize == SZ_BYTE && hostAddr == ADDR_W'(OFF_HOSTCTL)) |-> ((regWdata[7:0] & RSVD_MASK) == 8'h00));

endmodule

// File: rtl/sdhc_reg_adapter.sv
module sdhc_reg_adapter
  import sdhc_adapt_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter logic [7:0] RSVD_MASK    = 8'h04,
  parameter logic [7:0] ADMA_MIN_VER = 8'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic              hostReady,
  output logic [31:0]       hostRdata,
  input  logic [7:0]        vendorVer,
  input  logic              wrongVerQuirk,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [31:0]       regWdata,
  input  logic [31:0]       regRdata
);

  accSize_e    accSize;
  ctrlStrobe_t strobe;

  assign accSize = accSize_e'(hostSize);

  sdhc_adapt_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .accSize(accSize), .hostAddr(hostAddr), .strobe(strobe), .hostReady(hostReady)
  );

  sdhc_adapt_dp #(
    .ADDR_W(ADDR_W), .RSVD_MASK(RSVD_MASK), .ADMA_MIN_VER(ADMA_MIN_VER), .FIXED_VER(16'h1301)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWe(hostWe), .accSize(accSize),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .vendorVer(vendorVer),
    .wrongVerQuirk(wrongVerQuirk), .regRdata(regRdata), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .hostRdata(hostRdata)
  );

endmodule

// File: tb/test_sdhc_reg_adapter.sv
`timescale 1ns/1ps
module test_sdhc_reg_adapter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWe = 1'b0;
  logic [1:0]  hostSize = 2'd2;
  logic [7:0]  hostAddr = 8'h00;
  logic [31:0] hostWdata = 32'h0;
  logic        hostReady;
  logic [31:0] hostRdata;
  logic [7:0]  vendorVer = 8'h13;
  logic        wrongVerQuirk = 1'b0;
  logic [7:0]  regAddr;
  logic        regWe;
  logic [31:0] regWdata, regRdata;

  logic [31:0] mem [64];
  int          wrCount = 0;
  int          nChecks = 0, nFails = 0;
  bit          finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  sdhc_reg_adapter i_sdhc_reg_adapter (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe), .hostSize(hostSize),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostReady(hostReady), .hostRdata(hostRdata),
    .vendorVer(vendorVer), .wrongVerQuirk(wrongVerQuirk), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  // backing register file model
  assign regRdata = mem[regAddr[7:2]];
  always @(posedge clk) if (regWe) begin
    mem[regAddr[7:2]] <= regWdata;
    wrCount <= wrCount + 1;
  end

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 8'h10, 32'hA1B2C3D4, 32'h0,        8'd1},  // R1
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'hA1B2C3D4, 8'd1},  // R1
    '{1'b0, 2'd0, 8'h11, 32'h0,        32'h000000C3, 8'd2},  // R2
    '{1'b0, 2'd0, 8'h13, 32'h0,        32'h000000A1, 8'd2},  // R2
    '{1'b0, 2'd1, 8'h12, 32'h0,        32'h0000A1B2, 8'd3},  // R3
    '{1'b0, 2'd1, 8'h10, 32'h0,        32'h0000C3D4, 8'd3},  // R3
    '{1'b1, 2'd0, 8'h12, 32'h0000005A, 32'h0,        8'd2},  // R2
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'hA15AC3D4, 8'd2},  // R2
    '{1'b1, 2'd1, 8'h12, 32'h00001234, 32'h0,        8'd3},  // R3
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'h1234C3D4, 8'd3},  // R3
    '{1'b1, 2'd2, 8'h24, 32'hC38ABCDE, 32'h0,        8'd4},  // R4
    '{1'b0, 2'd2, 8'h24, 32'h0,        32'h013ABCDE, 8'd4},  // R4
    '{1'b1, 2'd2, 8'h24, 32'h507FFFFF, 32'h0,        8'd4},  // R4
    '{1'b0, 2'd2, 8'h24, 32'h0,        32'h000FFFFF, 8'd4},  // R4
    '{1'b1, 2'd2, 8'h40, 32'h00100000, 32'h0,        8'd5},  // R5
    '{1'b0, 2'd2, 8'h40, 32'h0,        32'h00180000, 8'd5},  // R5
    '{1'b1, 2'd2, 8'h40, 32'h00000001, 32'h0,        8'd5},  // R5
    '{1'b0, 2'd2, 8'h40, 32'h0,        32'h00000001, 8'd5},  // R5
    '{1'b1, 2'd2, 8'h34, 32'h00000001, 32'h0,        8'd11}, // R11
    '{1'b0, 2'd2, 8'h34, 32'h0,        32'h00000005, 8'd11}, // R11
    '{1'b1, 2'd3, 8'h34, 32'h00000000, 32'h0,        8'd11}, // R11 size code 3
    '{1'b0, 2'd2, 8'h34, 32'h0,        32'h00000004, 8'd11}, // R11
    '{1'b1, 2'd2, 8'h04, 32'hFFFFFFFF, 32'h0,        8'd10}, // R10
    '{1'b1, 2'd1, 8'h04, 32'h00007200, 32'h0,        8'd10}, // R10
    '{1'b0, 2'd2, 8'h04, 32'h0,        32'hFFFF0200, 8'd10}, // R10
    '{1'b1, 2'd2, 8'h0C, 32'h11112222, 32'h0,        8'd6},  // R6
    '{1'b1, 2'd1, 8'h0C, 32'h00000033, 32'h0,        8'd6},  // R6
    '{1'b0, 2'd2, 8'h0C, 32'h0,        32'h11112222, 8'd6},  // R6
    '{1'b1, 2'd1, 8'h0E, 32'h00000A1B, 32'h0,        8'd6},  // R6
    '{1'b0, 2'd2, 8'h0C, 32'h0,        32'h0A1B0033, 8'd6},  // R6
    '{1'b1, 2'd2, 8'h28, 32'h00005518, 32'h0,        8'd7},  // R7
    '{1'b1, 2'd0, 8'h29, 32'h000000FF, 32'h0,        8'd7},  // R7
    '{1'b0, 2'd2, 8'h28, 32'h0,        32'h00005518, 8'd7},  // R7
    '{1'b1, 2'd0, 8'h28, 32'h00000017, 32'h0,        8'd8},  // R8
    '{1'b0, 2'd2, 8'h28, 32'h0,        32'h0000561B, 8'd8},  // R8
    '{1'b0, 2'd0, 8'h28, 32'h0,        32'h00000013, 8'd9},  // R9
    '{1'b0, 2'd0, 8'h29, 32'h0,        32'h00000056, 8'd9},  // R9 other lane untouched
    '{1'b1, 2'd2, 8'hFC, 32'h14020000, 32'h0,        8'd12}, // R12
    '{1'b0, 2'd1, 8'hFE, 32'h0,        32'h00001402, 8'd12}  // R12
  };

  task automatic check(input int tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [7:0] addr,
                        input logic [31:0] data, output logic [31:0] rd, output logic rdy);
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostSize = sz; hostAddr = addr; hostWdata = data;
    @(posedge clk);
    @(negedge clk);
    rd = hostRdata; rdy = hostReady;
    hostReq = 1'b0; hostWe = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic        rdy;
    int          w0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(13, {31'b0, hostReady}, 32'h0);  // R13 reset state
    check(13, hostRdata, 32'h0);           // R13 reset state
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].we, VECS[i].sz, VECS[i].addr, VECS[i].data, rd, rdy);
      if (!VECS[i].we) check(int'(VECS[i].tag), rd, VECS[i].exp);
    end

    // R12: quirk forces the fixed version answer
    wrongVerQuirk = 1'b1;
    access(1'b0, 2'd1, 8'hFE, 32'h0, rd, rdy);
    check(12, rd, 32'h00001301);
    wrongVerQuirk = 1'b0;

    // R5: vendor version at threshold gives no extra capability
    vendorVer = 8'h12;
    access(1'b1, 2'd2, 8'h40, 32'h00100000, rd, rdy);
    access(1'b0, 2'd2, 8'h40, 32'h0, rd, rdy);
    check(5, rd, 32'h00100000);
    vendorVer = 8'h13;

    // R13: exactly one ready pulse and one backing write for a byte write
    w0 = wrCount;
    @(negedge clk);
    hostReq = 1'b1; hostWe = 1'b1; hostSize = 2'd0; hostAddr = 8'h31; hostWdata = 32'h000000EE;
    @(negedge clk);
    check(13, {31'b0, hostReady}, 32'h1);
    hostReq = 1'b0; hostWe = 1'b0;
    @(negedge clk);
    check(13, {31'b0, hostReady}, 32'h0);
    check(13, wrCount - w0, 32'd1);
    access(1'b0, 2'd2, 8'h30, 32'h0, rd, rdy);
    check(2, rd, 32'h0000EE00);  // R2 lane 1 write

    // R6: reset clears the held transfer-mode value
    access(1'b1, 2'd1, 8'h0C, 32'h00000077, rd, rdy);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    access(1'b1, 2'd1, 8'h0E, 32'h0000BEEF, rd, rdy);
    access(1'b0, 2'd2, 8'h0C, 32'h0, rd, rdy);
    check(6, rd, 32'hBEEF0000);

    finish_run();
  end

endmodule